// File: doc/BRIEF.md
# Start-of-Frame Tick Generator with Late-Frame Watchdog

This block produces the start-of-frame status flag and a matching one-cycle tick for a controller that can act as either a USB host or a USB device. In host role it is a free-running frame timer that fires once per 125 µs microframe. It only advances while the PHY clock runs and the port is out of suspend, so a stopped or suspended link produces no ticks.

In device role the timer follows start-of-frame tokens reported by the token decoder. Every received token fires a tick and restarts the count. If an expected token fails to arrive, a watchdog waits for the nominal interval plus a margin and then fires a synthetic tick. The nominal interval is 1 ms at full speed and 125 µs at high speed. The margin is the interval shifted right by a parameter. Before connection the link is treated as full speed, and the timer free-runs at the nominal 1 ms. The flag is sticky and software clears it by writing 1. A set event in the same cycle as a clear wins.

All intervals come from a clock-rate parameter given in kHz. The high-speed interval is `CLK_KHZ/8` cycles and the full-speed interval is `CLK_KHZ` cycles.

Top module: `sof_tick_wdog`

## Requirements
- R1: While `rst_n` is low, `sof_tick` and `sof_flag` are 0, and the frame count restarts from zero.
- R2: In host role (`dev_mode`=0), with `phy_clk_on`=1 and `port_susp`=0, `sof_tick` pulses once every `CLK_KHZ/8` cycles, whatever the state of `hs_sel`, `connected` and `sof_rx`.
- R3: In host role, while `phy_clk_on`=0 or `port_susp`=1, no tick is produced and the count holds its value. It resumes from that value afterwards.
- R4: In device role (`dev_mode`=1), a cycle with `sof_rx`=1 produces `sof_tick`=1 in the next cycle and restarts the count from zero.
- R5: In device role with `connected`=1, if no `sof_rx` arrives for N + (N >> `MARGIN_SH`) cycles after the last restart, a synthetic tick is produced and the count restarts. N is the nominal interval for the current speed.
- R6: In device role, N is `CLK_KHZ/8` when `hs_sel`=1 and `connected`=1, and `CLK_KHZ` otherwise.
- R7: In device role with `connected`=0, the timer free-runs and ticks every `CLK_KHZ` cycles without any margin.
- R8: `sof_flag` goes to 1 in the cycle `sof_tick` is 1. It stays 1 until a cycle with `clr_w1c`=1 and no new event, and then reads 0 in the following cycle.
- R9: When a tick event and `clr_w1c`=1 fall in the same cycle, `sof_flag` is 1 afterwards.
- R10: `sof_tick` is high for exactly one cycle per event, registered one cycle after the event condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_clk_on | input | 1 | PHY clock is present and running |
| port_susp | input | 1 | Port is in suspend |
| dev_mode | input | 1 | 1 = device role, 0 = host role |
| hs_sel | input | 1 | 1 = high speed, 0 = full speed |
| connected | input | 1 | Device is attached to the bus |
| sof_rx | input | 1 | One-cycle pulse per received start-of-frame token |
| clr_w1c | input | 1 | Software write of 1 to the flag |
| sof_flag | output | 1 | Sticky start-of-frame status |
| sof_tick | output | 1 | One-cycle pulse per frame event |

## Verification
The hardest case to reach from the ports is a clear strobe that falls on exactly the cycle of a tick event, including a synthetic tick produced by the watchdog. The bench holds `clr_w1c` high through whole frame periods, so every event boundary in that window is a collision. A cycle-by-cycle model then checks the flag on every clock. Speed and connection are also switched in the middle of a count. This checks that a count already past a shorter limit fires at once rather than wrapping.

// File: rtl/sof_pkg.sv
package sof_pkg;

  // Which interval governs the frame timer in the current cycle.
  typedef enum logic [1:0] {
    WIN_HOST_UF  = 2'd0,
    WIN_DEV_FREE = 2'd1,
    WIN_DEV_HS   = 2'd2,
    WIN_DEV_FS   = 2'd3
  } win_e;

endpackage

// File: rtl/sof_interval_sel.sv
module sof_interval_sel #(
  parameter int unsigned CLK_KHZ   = 60000,
  parameter int unsigned MARGIN_SH = 3,
  parameter int unsigned CNT_W     = 17
) (
  input  logic             dev_mode,
  input  logic             hs_sel,
  input  logic             connected,
  output sof_pkg::win_e    win,
  output logic [CNT_W-1:0] term
);
  import sof_pkg::*;

  localparam int unsigned HS_CYC  = CLK_KHZ / 8;
  localparam int unsigned FS_CYC  = CLK_KHZ;
  localparam int unsigned HS_LATE = HS_CYC + (HS_CYC >> MARGIN_SH);
  localparam int unsigned FS_LATE = FS_CYC + (FS_CYC >> MARGIN_SH);

  localparam logic [CNT_W-1:0] T_HOST = CNT_W'(HS_CYC - 1);
  localparam logic [CNT_W-1:0] T_FREE = CNT_W'(FS_CYC - 1);
  localparam logic [CNT_W-1:0] T_HS   = CNT_W'(HS_LATE - 1);
  localparam logic [CNT_W-1:0] T_FS   = CNT_W'(FS_LATE - 1);

  always_comb begin
    if (!dev_mode)       win = WIN_HOST_UF;
    else if (!connected) win = WIN_DEV_FREE;
    else if (hs_sel)     win = WIN_DEV_HS;
    else                 win = WIN_DEV_FS;
  end

  always_comb begin
    unique case (win)
      WIN_HOST_UF:  term = T_HOST;
      WIN_DEV_FREE: term = T_FREE;
      WIN_DEV_HS:   term = T_HS;
      default:      term = T_FS;
    endcase
  end

endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sof_take,
  input  logic [CNT_W-1:0] term,
  output logic             evt,
  output logic [CNT_W-1:0] cnt
);

  logic             cnt_en;
  logic             expire;
  logic [CNT_W-1:0] cnt_d;

  // A count already past a freshly shortened window fires at once.
  assign expire = run && (cnt >= term);
  assign evt    = sof_take || expire;
  assign cnt_en = run || sof_take;

  always_comb begin
    if (evt) cnt_d = '0;
    else     cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/sof_status_flag.sv
module sof_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_w1c,
  output logic flag,
  output logic tick
);

  logic flag_d;
  logic flag_en;

  // Set has priority over the software clear.
  assign flag_en = evt || clr_w1c;
  assign flag_d  = evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= evt;
  end

endmodule

// File: rtl/sof_tick_wdog.sv
module sof_tick_wdog #(
  parameter int unsigned CLK_KHZ   = 60000,
  parameter int unsigned MARGIN_SH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_clk_on,
  input  logic port_susp,
  input  logic dev_mode,
  input  logic hs_sel,
  input  logic connected,
  input  logic sof_rx,
  input  logic clr_w1c,
  output logic sof_flag,
  output logic sof_tick
);
  import sof_pkg::*;

  localparam int unsigned FS_LATE = CLK_KHZ + (CLK_KHZ >> MARGIN_SH);
  localparam int unsigned CNT_W   = $clog2(FS_LATE + 1);

  win_e             win;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] frame_cnt;
  logic             run;
  logic             sof_take;
  logic             tick_evt;

  assign run      = dev_mode || (phy_clk_on && !port_susp);
  assign sof_take = dev_mode && sof_rx;

  sof_interval_sel #(
    .CLK_KHZ  (CLK_KHZ),
    .MARGIN_SH(MARGIN_SH),
    .CNT_W    (CNT_W)
  ) u_sel (
    .dev_mode (dev_mode),
    .hs_sel   (hs_sel),
    .connected(connected),
    .win      (win),
    .term     (term)
  );

  sof_frame_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sof_take(sof_take),
    .term    (term),
    .evt     (tick_evt),
    .cnt     (frame_cnt)
  );

  sof_status_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (tick_evt),
    .clr_w1c(clr_w1c),
    .flag   (sof_flag),
    .tick   (sof_tick)
  );

endmodule

// File: rtl/sof_tick_wdog_chk.sv
module sof_tick_wdog_chk #(
  parameter int unsigned CNT_W   = 17,
  parameter int unsigned FS_LATE = 67500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phy_clk_on,
  input logic             port_susp,
  input logic             dev_mode,
  input logic             sof_rx,
  input logic             clr_w1c,
  input logic             sof_flag,
  input logic             sof_tick,
  input logic             tick_evt,
  input logic [CNT_W-1:0] frame_cnt
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!sof_tick && !sof_flag && frame_cnt == '0)
        else $error("reset state violated");
    end
  end

  a_r3_gated_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_mode && (!phy_clk_on || port_susp)) |=> (!sof_tick && $stable(frame_cnt)));

  a_r4_sof_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mode && sof_rx) |=> sof_tick);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_cnt) < FS_LATE);

  a_r8_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sof_tick |-> sof_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_flag && !clr_w1c) |=> sof_flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c && !tick_evt) |=> !sof_flag);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c && tick_evt) |=> sof_flag);

  a_r10_tick_follows_evt: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> sof_tick);

endmodule

bind sof_tick_wdog sof_tick_wdog_chk #(
  .CNT_W  (CNT_W),
  .FS_LATE(FS_LATE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phy_clk_on(phy_clk_on),
  .port_susp (port_susp),
  .dev_mode  (dev_mode),
  .sof_rx    (sof_rx),
  .clr_w1c   (clr_w1c),
  .sof_flag  (sof_flag),
  .sof_tick  (sof_tick),
  .tick_evt  (tick_evt),
  .frame_cnt (frame_cnt)
);

// File: tb/tb_sof_tick_wdog.sv
module tb_sof_tick_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 128;
  localparam int SH         = 3;
  localparam int HS_N       = KHZ / 8;
  localparam int FS_N       = KHZ;

  logic clk, rst_n;
  logic phy_clk_on, port_susp, dev_mode, hs_sel, connected, sof_rx, clr_w1c;
  logic sof_flag, sof_tick;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  string cur_tag = "R1";

  sof_tick_wdog #(.CLK_KHZ(KHZ), .MARGIN_SH(SH)) dut (
    .clk(clk), .rst_n(rst_n), .phy_clk_on(phy_clk_on), .port_susp(port_susp),
    .dev_mode(dev_mode), .hs_sel(hs_sel), .connected(connected),
    .sof_rx(sof_rx), .clr_w1c(clr_w1c), .sof_flag(sof_flag), .sof_tick(sof_tick)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: elapsed-cycle counter plus sticky flag.
  int m_elapsed;
  bit m_tick, m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_elapsed = 0; m_tick = 0; m_flag = 0;
    end else begin
      int window;
      bit running, fire;
      running = dev_mode || (phy_clk_on && !port_susp);
      if (!dev_mode)        window = HS_N;
      else if (!connected)  window = FS_N;
      else if (hs_sel)      window = HS_N + HS_N / 8;
      else                  window = FS_N + FS_N / 8;
      fire = (dev_mode && sof_rx) || (running && (m_elapsed + 1 >= window));
      if (fire)         m_elapsed = 0;
      else if (running) m_elapsed = m_elapsed + 1;
      m_tick = fire;
      if (fire)         m_flag = 1;
      else if (clr_w1c) m_flag = 0;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sof_tick == m_tick, {cur_tag, " tick"}, sof_tick, m_tick);
      check(sof_flag == m_flag, {cur_tag, " flag"}, sof_flag, m_flag);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sof();
    sof_rx = 1; @(negedge clk); sof_rx = 0;
  endtask

  // Cycles between two consecutive ticks, sampled at negedges.
  task automatic gap_check(int expv, string tag);
    int n = 0;
    while (!sof_tick && n < 1000) begin @(negedge clk); n++; end
    n = 1; @(negedge clk);
    while (!sof_tick && n < 1000) begin @(negedge clk); n++; end
    check(n == expv, {tag, " interval"}, n, expv);
  endtask

  task automatic count_ticks(int n, int expv, string tag);
    int t = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (sof_tick) t++; end
    check(t == expv, {tag, " tick count"}, t, expv);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; phy_clk_on = 0; port_susp = 0; dev_mode = 0; hs_sel = 0;
    connected = 0; sof_rx = 0; clr_w1c = 0;
    run(3);
    // R1: reset state
    check(sof_tick == 0, "R1 tick", sof_tick, 0);
    check(sof_flag == 0, "R1 flag", sof_flag, 0);
    rst_n = 1;

    // R2: host microframe timer, speed/connect/token inputs irrelevant
    cur_tag = "R2"; phy_clk_on = 1;
    gap_check(HS_N, "R2");
    hs_sel = 1; connected = 1;
    gap_check(HS_N, "R2");
    sof_rx = 1; run(5); sof_rx = 0;
    gap_check(HS_N, "R2");

    // R3: gating by PHY clock and suspend
    cur_tag = "R3"; run(5); phy_clk_on = 0;
    count_ticks(3 * HS_N, 0, "R3 phy off");
    phy_clk_on = 1; port_susp = 1;
    count_ticks(3 * HS_N, 0, "R3 suspended");
    port_susp = 0;
    count_ticks(2 * HS_N, 2, "R3 resumed");

    // R8/R9: clear alone, then clear held across tick boundaries
    cur_tag = "R8"; clr_w1c = 1; @(negedge clk); clr_w1c = 0;
    run(3);
    check(sof_flag == 0 || sof_tick, "R8 cleared", sof_flag, 0);
    cur_tag = "R9"; clr_w1c = 1;
    run(3 * HS_N);
    clr_w1c = 0; cur_tag = "R8";
    run(HS_N);
    check(sof_flag == 1, "R8 sticky", sof_flag, 1);

    // R7: device, unattached, free-running full-speed nominal
    cur_tag = "R7"; dev_mode = 1; connected = 0; hs_sel = 1;
    run(2);
    gap_check(FS_N, "R7");
    pulse_sof();
    gap_check(FS_N, "R7");

    // R4/R5/R6: device attached at full speed
    cur_tag = "R4"; connected = 0; hs_sel = 0; connected = 1;
    for (int k = 0; k < 3; k++) begin
      run(100); pulse_sof();
      check(sof_tick == 1, "R4 token tick", sof_tick, 1);
    end
    cur_tag = "R5";
    gap_check(FS_N + FS_N / 8, "R5 FS late");
    gap_check(FS_N + FS_N / 8, "R5 FS repeat");

    // R6: high speed attached, tokens then missing
    cur_tag = "R6"; hs_sel = 1;
    for (int k = 0; k < 4; k++) begin
      run(13); pulse_sof();
      check(sof_tick == 1, "R4 hs token tick", sof_tick, 1);
    end
    gap_check(HS_N + HS_N / 8, "R6 HS late");
    // mid-count speed switch: count past shorter window fires at once
    cur_tag = "R6"; hs_sel = 0; run(60); hs_sel = 1;
    run(3);
    gap_check(HS_N + HS_N / 8, "R6 after switch");
    cur_tag = "R9"; clr_w1c = 1; run(3 * HS_N); clr_w1c = 0;
    // R10: tick is a single-cycle pulse on an isolated event
    cur_tag = "R10"; run(2); pulse_sof();
    check(sof_tick == 1, "R10 high", sof_tick, 1);
    @(negedge clk);
    check(sof_tick == 0, "R10 one cycle", sof_tick, 0);
    run(20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule